// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. The integrator capacitor and the comparator sit outside the block. It receives a conversion request, the comparator output and a clock. It drives a source-select line that connects either the unknown voltage or the reference voltage to the integrator. It returns an N-bit count that is proportional to the unknown input.

A request accepted in idle starts a charge phase of fixed length, 2^N clocks, with the unknown input selected. The counter then clears and the select line switches to the reference, which starts the discharge phase. The block counts discharge clocks until the synchronised comparator reports that the integrator has crossed back over its threshold. That count is latched into the result register and a done pulse lasting one cycle marks the update. Both phases are timed by the same clock, so slow drift in the clock frequency cancels out of the result.

If the discharge count reaches all ones without a trip, the result saturates and an overrange flag is raised. The comparator input is asynchronous and passes through two flip-flops before the sequencer uses it.

Top module: `dslope_seq`

## Requirements
- R1: After reset, sel_ref_o, busy_o, done_o and ovr_o are 0 and result_o is 0.
- R2: A start_i pulse while idle makes busy_o 1 with sel_ref_o 0 in the cycle after the capturing edge.
- R3: The charge phase lasts exactly 2^N clock cycles with sel_ref_o at 0 and busy_o at 1. After that, sel_ref_o is 1 (reference selected) until the conversion ends.
- R4: If cmp_i rises before the k-th clock edge of the discharge phase (k >= 1) and stays high, the result is k+1 for k <= 2^N-2. The extra count comes from the two-stage synchroniser. A comparator trip seen together with an all-ones count gives an all-ones result without overrange.
- R5: Each result update comes with done_o high for exactly one cycle. In that cycle busy_o and sel_ref_o are already 0.
- R6: start_i while busy_o is 1 has no effect: phase lengths and the result are unchanged, and no new conversion follows.
- R7: If no trip is seen before the discharge count reaches all ones, result_o becomes all ones and ovr_o is 1. A normal result clears ovr_o.
- R8: result_o and ovr_o hold their values between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock timing both phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Asynchronous comparator output, 1 = integrator has crossed back over the threshold |
| sel_ref_o | output | 1 | Integrator source: 0 = unknown input, 1 = reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse on each result update |
| ovr_o | output | 1 | Last result saturated without a comparator trip |
| result_o | output | RES_W | Discharge count of the last conversion |

## Verification
The hardest cases to reach from the ports are the last few discharge counts. These are where a trip lands exactly on the all-ones count, one count before it, or one count too late, and the synchroniser delay decides which of them happens. The bench runs the charge phase to completion and then raises the comparator at every possible discharge edge from the first to beyond full scale. It also holds the comparator low for a whole conversion. On alternate runs it injects stray start requests inside both phases.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_UP   = 2'd1,
    PH_DOWN = 2'd2
  } phase_t;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dslope_counter.sv
module dslope_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic trip_i,
  input  logic full_i,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic load_o,
  output logic sat_o,
  output logic sel_ref_o,
  output logic busy_o
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d      = ph_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    load_o    = 1'b0;
    sat_o     = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d      = PH_UP;
          cnt_clr_o = 1'b1;
        end
      end
      PH_UP: begin
        if (full_i) begin
          ph_d      = PH_DOWN;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      PH_DOWN: begin
        if (trip_i) begin
          ph_d   = PH_IDLE;
          load_o = 1'b1;
        end else if (full_i) begin
          ph_d  = PH_IDLE;
          sat_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign sel_ref_o = (ph_q == PH_DOWN);
  assign busy_o    = (ph_q != PH_IDLE);
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int RES_W     = 10,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sel_ref_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic [RES_W-1:0] result_o
);
  logic             trip_s;
  logic             cnt_clr, cnt_inc, cnt_full;
  logic             load, sat;
  logic [RES_W-1:0] cnt;
  logic [RES_W-1:0] res_q;
  logic             ovr_q, done_q;

  dslope_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (trip_s)
  );

  dslope_counter #(.W(RES_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt),
    .full_o (cnt_full)
  );

  dslope_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .trip_i    (trip_s),
    .full_i    (cnt_full),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .load_o    (load),
    .sat_o     (sat),
    .sel_ref_o (sel_ref_o),
    .busy_o    (busy_o)
  );

  // result register: written only when a conversion ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovr_q <= 1'b0;
    end else if (load) begin
      res_q <= cnt;
      ovr_q <= 1'b0;
    end else if (sat) begin
      res_q <= '1;
      ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= load | sat;
  end

  assign result_o = res_q;
  assign ovr_o    = ovr_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             sel_ref_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic [RES_W-1:0] result_o
);
  localparam int UP_LEN = 1 << RES_W;
  logic [RES_W+1:0] up_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    up_cyc <= '0;
    else if (!busy_o)              up_cyc <= '0;
    else if (busy_o && !sel_ref_o) up_cyc <= up_cyc + (RES_W+2)'(1);
  end

  // R3: reference selected only inside a conversion
  a_r3_ref_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ref_o |-> busy_o);

  // R3: charge phase length counted in the checker
  a_r3_up_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref_o) |-> (up_cyc == (RES_W+2)'(UP_LEN)));

  // R2 / R6: a conversion only begins from an accepted request
  a_r6_begin_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R5: done is a single-cycle pulse after leaving the busy state
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7: overrange implies a saturated result
  a_r7_ovr_sat: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (&result_o));

  // R8: outputs hold between updates
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> ($stable(result_o) || done_o));
endmodule

bind dslope_seq dslope_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .sel_ref_o (sel_ref_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ovr_o     (ovr_o),
  .result_o  (result_o)
);

// File: tb/tb_dslope_seq.sv
`timescale 1ns/1ps
module tb_dslope_seq;
  localparam int N    = 5;
  localparam int FULL = (1 << N) - 1;

  logic         clk, rst_n, start_i, cmp_i;
  logic         sel_ref_o, busy_o, done_o, ovr_o;
  logic [N-1:0] result_o;
  int           total, bad;
  int           wd;

  dslope_seq #(.RES_W(N)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cmp_i     (cmp_i),
    .sel_ref_o (sel_ref_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ovr_o     (ovr_o),
    .result_o  (result_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<=150000", wd);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  // k: comparator raised before the k-th discharge edge
  task automatic convert(input int k, input bit inject);
    int up, seen, exp_res, exp_ovr;
    logic [N-1:0] held;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R2 busy", busy_o, 1);
    check("R2 sel", sel_ref_o, 0);
    up = 1;
    while (!sel_ref_o && up < 4 * (FULL + 1)) begin
      start_i = (inject && up == 5);
      @(negedge clk);
      if (!sel_ref_o) up++;
    end
    start_i = 1'b0;
    check("R3 runup len", up, FULL + 1);
    seen = 1;
    while (!done_o && seen < 4 * (FULL + 1)) begin
      if (seen == k) cmp_i = 1'b1;
      start_i = (inject && seen == 2);
      @(negedge clk);
      if (!done_o) begin
        check("R3 ref held", sel_ref_o, 1);
        seen++;
      end
    end
    start_i = 1'b0;
    exp_res = (k <= FULL - 1) ? k + 1 : FULL;
    exp_ovr = (k <= FULL - 1) ? 0 : 1;
    check("R4/R7 result", result_o, exp_res);
    check("R7 ovr", ovr_o, exp_ovr);
    check("R5 busy at done", busy_o, 0);
    check("R5 sel at done", sel_ref_o, 0);
    held = result_o;
    @(negedge clk);
    cmp_i = 1'b0;
    check("R5 done width", done_o, 0);
    check("R6 no restart", busy_o, 0);
    repeat (4) @(negedge clk);
    check("R8 hold", result_o, held);
    check("R8 ovr hold", ovr_o, exp_ovr);
  endtask

  initial begin
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    cmp_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sel", sel_ref_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 ovr", ovr_o, 0);
    check("R1 result", result_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // sweep every trip position, including full scale and beyond
    for (int k = 1; k <= FULL + 2; k++) convert(k, k[0]);
    // normal result after overrange clears the flag (R7)
    convert(3, 1'b1);
    // comparator stuck low: R7 saturation
    convert(100000, 1'b0);
    convert(FULL - 1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule